// File: doc/BRIEF.md
# MAC Address Lookup Table Controller

This block manages a small forwarding table of MAC address entries for an Ethernet switch. Software writes a 48-bit key and a set of entry fields into two data registers. It then writes a command word into a control register. The controller carries the command out against the table and sets a busy flag for as long as the operation runs. Software polls that flag and reads the results back from the same registers.

Single-entry commands are lookup, read, write and clear. Two commands walk the whole table one entry per cycle: a port flush, which strips a set of ports from every entry, and a table wipe, which is started from a separate table-control register. A learned-entry counter sits beside the table, and software moves it up, down or back to zero. The table index is taken directly from the last MAC byte. Entries carry no VLAN tag, so each address has exactly one slot.

Top module: `lut_ctrl_top`

## Requirements
- R1: After reset every table entry is invalid, and all register read values (control, both data registers, learn count, wipe flag) are zero.
- R2: A control write (select 0) that has at least one command bit set (lookup bit 16, write 17, clear 18, read 19, port flush 21) sets busy (control bit 31) on the next cycle. Lookup, read, write and clear hold busy for exactly one cycle. Port flush and wipe hold busy for DEPTH cycles. Every control write copies data bits 7:0 into the address field (control bits 7:0).
- R3: While busy is set, writes to the control, low data, high data and table-control registers are ignored. Learn-count writes are still accepted.
- R4: A lookup computes the index from the key. The key is MAC bytes 0–3 in the low data register (byte 0 in bits 7:0) and bytes 4–5 in high data bits 15:0. If the entry at that index is valid and its MAC equals the key, the lookup puts the index in the address field and loads the entry into the high data register. High data layout: port mask in bits 20:16, priority in 22:21, static in 23, valid in 24.
- R5: A lookup that finds the slot invalid, or finds it holding a different MAC, returns the index with high data valid=0, static=0, priority=0 and port mask all ones. The key bytes in high data bits 15:0 are kept.
- R6: A write stores both data registers into the entry at the address field. A read loads that entry into the high data register only. A read with the wait bit (bit 20) also loads MAC bytes 0–3 into the low data register.
- R7: A clear command invalidates the entry at the address field and zeroes all of its fields.
- R8: A port flush takes a port bitmap in control bits 4:0 and removes those ports from the mask of every entry. An entry whose mask becomes empty and that is not static is invalidated. A static entry stays valid even with an empty mask.
- R9: Writing 1 to bit 0 of the table-control register (select 4) starts a wipe. The wipe flag reads 1 until every entry has been invalidated, which takes DEPTH cycles, and then clears by itself.
- R10: A learn-count write (select 3) applies a mode from data bits 1:0: 1 increments, 2 decrements, 3 sets the count to zero, and 0 leaves it unchanged. The count saturates at 0 and at DEPTH.
- R11: When a control write sets several command bits, only one command runs. The priority order is lookup, then write, then clear, then read, then port flush.
- R12: The table index is the low log2(DEPTH) bits of MAC byte 5. Two addresses that share those bits compete for the same slot, so a lookup of one reads as a miss while the other occupies the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 low data, 2 high data, 3 learn count, 4 table control |
| reg_wdata | input | 32 | Register write data |
| ctrl_q | output | 32 | Control read value: busy in bit 31, address field in bits 7:0 |
| data_lo_q | output | 32 | Low data register: MAC bytes 0–3 |
| data_hi_q | output | 32 | High data register: MAC bytes 4–5, port mask, priority, static, valid |
| learn_cnt_q | output | CNT_W | Learned-entry counter |
| wipe_q | output | 1 | Table wipe in progress |

## Verification
Lookups are run against a slot that is empty, one that holds the same address, and one that holds a different address with the same index byte. These three cases separate a hit from a miss and from a collision. Reads with and without the wait bit show whether the low register is reloaded. The port flush is run over static and dynamic entries, with bitmaps that empty some masks but not others, so it shows which entries are invalidated and which only lose ports. Writes sent during a long scan, command words with several bits set, and learn-count steps past both ends show that writes are rejected while busy, that the command priority holds, and that the counter saturates.

// File: rtl/lut_pkg.sv
package lut_pkg;

    localparam int NUM_PORTS  = 5;
    localparam int PRIO_W     = 2;
    localparam int MAC_W      = 48;
    localparam int LO_W       = 32;
    localparam int MACHI_W    = MAC_W - LO_W;
    localparam int REG_W      = 32;
    localparam int ADDR_FLD_W = 8;

    // command word bit positions
    localparam int B_LOOKUP  = 16;
    localparam int B_WRITE   = 17;
    localparam int B_CLEAR   = 18;
    localparam int B_READ    = 19;
    localparam int B_WAIT    = 20;
    localparam int B_DELPORT = 21;
    localparam int B_BUSY    = 31;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_LO    = 3'd1;
    localparam logic [2:0] SEL_HI    = 3'd2;
    localparam logic [2:0] SEL_LCNT  = 3'd3;
    localparam logic [2:0] SEL_TABLE = 3'd4;

    localparam logic [1:0] LC_HOLD = 2'd0;
    localparam logic [1:0] LC_INC  = 2'd1;
    localparam logic [1:0] LC_DEC  = 2'd2;
    localparam logic [1:0] LC_ZERO = 2'd3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOOKUP,
        OP_WRITE,
        OP_CLEAR,
        OP_READ,
        OP_DELPORT,
        OP_WIPE
    } op_e;

    // high data register image (valid is the top bit)
    typedef struct packed {
        logic                 valid;
        logic                 stat;
        logic [PRIO_W-1:0]    prio;
        logic [NUM_PORTS-1:0] pmask;
        logic [MACHI_W-1:0]   mac_hi;
    } hi_t;

    // stored table entry
    typedef struct packed {
        logic                 valid;
        logic                 stat;
        logic [PRIO_W-1:0]    prio;
        logic [NUM_PORTS-1:0] pmask;
        logic [MAC_W-1:0]     mac;
    } entry_t;

    localparam int HI_W = $bits(hi_t);

    function automatic hi_t entry_to_hi(entry_t e);
        hi_t h;
        h.valid  = e.valid;
        h.stat   = e.stat;
        h.prio   = e.prio;
        h.pmask  = e.pmask;
        h.mac_hi = e.mac[MAC_W-1:LO_W];
        return h;
    endfunction

    function automatic entry_t regs_to_entry(logic [LO_W-1:0] lo, hi_t h);
        entry_t e;
        e.valid = h.valid;
        e.stat  = h.stat;
        e.prio  = h.prio;
        e.pmask = h.pmask;
        e.mac   = {h.mac_hi, lo};
        return e;
    endfunction

    // fixed priority among command bits
    function automatic op_e decode_cmd(logic [REG_W-1:0] w);
        if (w[B_LOOKUP])  return OP_LOOKUP;
        if (w[B_WRITE])   return OP_WRITE;
        if (w[B_CLEAR])   return OP_CLEAR;
        if (w[B_READ])    return OP_READ;
        if (w[B_DELPORT]) return OP_DELPORT;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/lut_hash.sv
module lut_hash
    import lut_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [MAC_W-1:0] mac,
    output logic [AW-1:0]    idx
);

    localparam int TOP_BYTE_LSB = MAC_W - 8;

    generate
        if (AW <= 8) begin : g_byte
            assign idx = mac[TOP_BYTE_LSB +: AW];
        end else begin : g_wide
            assign idx = mac[MAC_W-1 -: AW];
        end
    endgenerate

endmodule

// File: rtl/lut_store.sv
module lut_store
    import lut_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_idx,
    output entry_t        rd_entry,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  entry_t        wr_entry
);

    entry_t mem [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[g] <= '0;
                end else if (wr_en && (wr_idx == AW'(g))) begin
                    mem[g] <= wr_entry;
                end
            end
        end
    endgenerate

    assign rd_entry = mem[rd_idx];

endmodule

// File: rtl/lut_learn_cnt.sv
module lut_learn_cnt
    import lut_pkg::*;
#(
    parameter int MAXV = 16,
    parameter int CW   = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [1:0]    mode,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP = CW'(MAXV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (upd) begin
            unique case (mode)
                LC_INC:  if (cnt != TOP) cnt <= cnt + 1'b1;
                LC_DEC:  if (cnt != '0)  cnt <= cnt - 1'b1;
                LC_ZERO: cnt <= '0;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/lut_seq.sv
module lut_seq
    import lut_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [2:0]            reg_sel,
    input  logic [REG_W-1:0]      reg_wdata,
    input  logic [AW-1:0]         hash_idx,
    input  entry_t                rd_entry,
    output logic [AW-1:0]         rd_idx,
    output logic                  st_we,
    output entry_t                st_entry,
    output logic [MAC_W-1:0]      key_mac,
    output logic [LO_W-1:0]       lo_q,
    output hi_t                   hi_q,
    output logic [ADDR_FLD_W-1:0] addr_q,
    output logic                  busy_q,
    output logic                  wipe_q
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    op_e                  op_q;
    logic [AW-1:0]        scan_q;
    logic [NUM_PORTS-1:0] bitmap_q;
    logic                 wait_q;
    logic                 hit;
    entry_t               scrub;
    hi_t                  miss_hi;
    op_e                  new_op;

    assign key_mac = {hi_q.mac_hi, lo_q};
    assign hit     = rd_entry.valid && (rd_entry.mac == key_mac);
    assign new_op  = decode_cmd(reg_wdata);

    // which slot the current operation touches
    always_comb begin
        unique case (op_q)
            OP_LOOKUP:          rd_idx = hash_idx;
            OP_DELPORT, OP_WIPE: rd_idx = scan_q;
            default:            rd_idx = addr_q[AW-1:0];
        endcase
    end

    always_comb begin
        miss_hi        = '0;
        miss_hi.pmask  = '1;
        miss_hi.mac_hi = hi_q.mac_hi;
    end

    // entry after removing the flushed ports
    always_comb begin
        scrub       = rd_entry;
        scrub.pmask = rd_entry.pmask & ~bitmap_q;
        if ((scrub.pmask == '0) && !scrub.stat) begin
            scrub = '0;
        end
    end

    always_comb begin
        st_we    = 1'b0;
        st_entry = '0;
        if (busy_q) begin
            unique case (op_q)
                OP_WRITE: begin
                    st_we    = 1'b1;
                    st_entry = regs_to_entry(lo_q, hi_q);
                end
                OP_CLEAR, OP_WIPE: st_we = 1'b1;
                OP_DELPORT: begin
                    st_we    = 1'b1;
                    st_entry = scrub;
                end
                default: st_we = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            wipe_q   <= 1'b0;
            op_q     <= OP_NONE;
            scan_q   <= '0;
            bitmap_q <= '0;
            wait_q   <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            addr_q   <= '0;
        end else if (busy_q) begin
            unique case (op_q)
                OP_LOOKUP: begin
                    addr_q <= ADDR_FLD_W'(hash_idx);
                    hi_q   <= hit ? entry_to_hi(rd_entry) : miss_hi;
                    busy_q <= 1'b0;
                end
                OP_READ: begin
                    hi_q <= entry_to_hi(rd_entry);
                    if (wait_q) begin
                        lo_q <= rd_entry.mac[LO_W-1:0];
                    end
                    busy_q <= 1'b0;
                end
                OP_DELPORT, OP_WIPE: begin
                    if (scan_q == LAST) begin
                        busy_q <= 1'b0;
                        wipe_q <= 1'b0;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                default: busy_q <= 1'b0;
            endcase
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    addr_q <= reg_wdata[ADDR_FLD_W-1:0];
                    if (new_op != OP_NONE) begin
                        busy_q   <= 1'b1;
                        op_q     <= new_op;
                        scan_q   <= '0;
                        bitmap_q <= reg_wdata[NUM_PORTS-1:0];
                        wait_q   <= reg_wdata[B_WAIT];
                    end
                end
                SEL_LO: lo_q <= reg_wdata;
                SEL_HI: hi_q <= reg_wdata[HI_W-1:0];
                SEL_TABLE: begin
                    if (reg_wdata[0]) begin
                        busy_q <= 1'b1;
                        wipe_q <= 1'b1;
                        op_q   <= OP_WIPE;
                        scan_q <= '0;
                    end
                end
                default: addr_q <= addr_q;
            endcase
        end
    end

endmodule

// File: rtl/lut_ctrl_top.sv
module lut_ctrl_top
    import lut_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      ctrl_q,
    output logic [31:0]      data_lo_q,
    output logic [31:0]      data_hi_q,
    output logic [CNT_W-1:0] learn_cnt_q,
    output logic             wipe_q
);

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]         hash_idx;
    logic [AW-1:0]         rd_idx;
    entry_t                rd_entry;
    logic                  st_we;
    entry_t                st_entry;
    logic [MAC_W-1:0]      key_mac;
    logic [LO_W-1:0]       lo_q;
    hi_t                   hi_q;
    logic [ADDR_FLD_W-1:0] addr_q;
    logic                  busy_q;

    lut_hash #(.AW(AW)) u_hash (
        .mac (key_mac),
        .idx (hash_idx)
    );

    lut_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .wr_en    (st_we),
        .wr_idx   (rd_idx),
        .wr_entry (st_entry)
    );

    lut_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .hash_idx  (hash_idx),
        .rd_entry  (rd_entry),
        .rd_idx    (rd_idx),
        .st_we     (st_we),
        .st_entry  (st_entry),
        .key_mac   (key_mac),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .addr_q    (addr_q),
        .busy_q    (busy_q),
        .wipe_q    (wipe_q)
    );

    lut_learn_cnt #(.MAXV(DEPTH), .CW(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .upd  (reg_we && (reg_sel == SEL_LCNT)),
        .mode (reg_wdata[1:0]),
        .cnt  (learn_cnt_q)
    );

    assign ctrl_q    = {busy_q, {(REG_W - 1 - ADDR_FLD_W){1'b0}}, addr_q};
    assign data_lo_q = lo_q;
    assign data_hi_q = {{(REG_W - HI_W){1'b0}}, hi_q};

endmodule

// File: rtl/lut_ctrl_checker.sv
module lut_ctrl_checker
    import lut_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      data_lo_q,
    input logic [31:0]      data_hi_q,
    input logic [CNT_W-1:0] learn_cnt_q,
    input logic             wipe_q
);

    logic busy;
    assign busy = ctrl_q[B_BUSY];

    // R2: an accepted lookup is busy for one cycle only
    p_lookup_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_we && reg_sel == SEL_CTRL && reg_wdata[B_LOOKUP])
        |=> busy ##1 !busy);

    // R3: data registers cannot be written during a wipe
    p_data_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (wipe_q && reg_we) |=> ($stable(data_lo_q) && $stable(data_hi_q)));

    // R9: the wipe flag never shows without busy
    p_wipe_busy_r9: assert property (@(posedge clk) disable iff (rst)
        wipe_q |-> busy);

    // R10: the counter stays within the table size
    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        learn_cnt_q <= CNT_W'(DEPTH));

    // R10: zero mode empties the counter
    p_count_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_LCNT && reg_wdata[1:0] == LC_ZERO)
        |=> (learn_cnt_q == '0));

endmodule

bind lut_ctrl_top lut_ctrl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_lut_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .ctrl_q      (ctrl_q),
    .data_lo_q   (data_lo_q),
    .data_hi_q   (data_hi_q),
    .learn_cnt_q (learn_cnt_q),
    .wipe_q      (wipe_q)
);

// File: tb/test_lut_ctrl_top.sv
module test_lut_ctrl_top;
    import lut_pkg::*;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_sel = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      ctrl_q, data_lo_q, data_hi_q;
    logic [CNT_W-1:0] learn_cnt_q;
    logic             wipe_q;

    always #10 clk = ~clk;

    lut_ctrl_top #(.DEPTH(DEPTH)) i_lut_ctrl_top (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .ctrl_q (ctrl_q), .data_lo_q (data_lo_q),
        .data_hi_q (data_hi_q), .learn_cnt_q (learn_cnt_q), .wipe_q (wipe_q)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    entry_t               m_tab [DEPTH];
    logic [31:0]          m_lo;
    hi_t                  m_hi;
    logic [7:0]           m_addr;
    bit                   m_busy, m_wipe, m_wait, started;
    int                   m_cnt, m_scan;
    op_e                  m_op;
    logic [NUM_PORTS-1:0] m_bm;

    task automatic model_step();
        int     slot;
        entry_t e;
        case (m_op)
            OP_LOOKUP: begin
                slot   = (int'(m_hi.mac_hi) >> 8) % DEPTH;
                e      = m_tab[slot];
                m_addr = 8'(slot);
                if (e.valid && e.mac == {m_hi.mac_hi, m_lo}) begin
                    m_hi.valid = e.valid; m_hi.stat = e.stat; m_hi.prio = e.prio;
                    m_hi.pmask = e.pmask; m_hi.mac_hi = e.mac[47:32];
                end else begin
                    m_hi.valid = 0; m_hi.stat = 0; m_hi.prio = 0; m_hi.pmask = '1;
                end
                m_busy = 0;
            end
            OP_WRITE: begin
                slot = int'(m_addr) % DEPTH;
                e.valid = m_hi.valid; e.stat = m_hi.stat; e.prio = m_hi.prio;
                e.pmask = m_hi.pmask; e.mac = {m_hi.mac_hi, m_lo};
                m_tab[slot] = e;
                m_busy = 0;
            end
            OP_CLEAR: begin
                m_tab[int'(m_addr) % DEPTH] = '0;
                m_busy = 0;
            end
            OP_READ: begin
                e = m_tab[int'(m_addr) % DEPTH];
                m_hi.valid = e.valid; m_hi.stat = e.stat; m_hi.prio = e.prio;
                m_hi.pmask = e.pmask; m_hi.mac_hi = e.mac[47:32];
                if (m_wait) m_lo = e.mac[31:0];
                m_busy = 0;
            end
            default: begin
                if (m_op == OP_WIPE) begin
                    m_tab[m_scan] = '0;
                end else begin
                    e = m_tab[m_scan];
                    e.pmask = e.pmask & ~m_bm;
                    if (e.pmask == 0 && !e.stat) e = '0;
                    m_tab[m_scan] = e;
                end
                if (m_scan == DEPTH - 1) begin
                    m_busy = 0; m_wipe = 0;
                end else begin
                    m_scan++;
                end
            end
        endcase
    endtask

    task automatic model_accept();
        case (reg_sel)
            SEL_CTRL: begin
                m_addr = reg_wdata[7:0];
                if (reg_wdata[16] || reg_wdata[17] || reg_wdata[18] ||
                    reg_wdata[19] || reg_wdata[21]) begin
                    m_busy = 1; m_scan = 0;
                    m_bm   = reg_wdata[4:0];
                    m_wait = reg_wdata[20];
                    if (reg_wdata[16])      m_op = OP_LOOKUP;
                    else if (reg_wdata[17]) m_op = OP_WRITE;
                    else if (reg_wdata[18]) m_op = OP_CLEAR;
                    else if (reg_wdata[19]) m_op = OP_READ;
                    else                    m_op = OP_DELPORT;
                end
            end
            SEL_LO: m_lo = reg_wdata;
            SEL_HI: m_hi = reg_wdata[HI_W-1:0];
            SEL_TABLE: if (reg_wdata[0]) begin
                m_busy = 1; m_wipe = 1; m_op = OP_WIPE; m_scan = 0;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        bit was_busy;
        started = 1;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_tab[i] = '0;
            m_lo = 0; m_hi = '0; m_addr = 0; m_busy = 0; m_wipe = 0;
            m_wait = 0; m_cnt = 0; m_scan = 0; m_op = OP_NONE; m_bm = 0;
        end else begin
            was_busy = m_busy;
            if (reg_we && reg_sel == SEL_LCNT) begin
                if (reg_wdata[1:0] == 2'd1 && m_cnt < DEPTH) m_cnt++;
                else if (reg_wdata[1:0] == 2'd2 && m_cnt > 0) m_cnt--;
                else if (reg_wdata[1:0] == 2'd3) m_cnt = 0;
            end
            if (was_busy) model_step();
            else if (reg_we) model_accept();
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] e_ctrl;
        if (started && !done) begin
            e_ctrl = {m_busy, 23'd0, m_addr};
            n_chk++;
            if (ctrl_q !== e_ctrl || data_lo_q !== m_lo ||
                data_hi_q !== 32'(m_hi) || learn_cnt_q !== CNT_W'(m_cnt) ||
                wipe_q !== m_wipe) begin
                n_bad++;
                $display("FAIL %s model compare: ctrl=%h/%h lo=%h/%h hi=%h/%h cnt=%0d/%0d wipe=%b/%b",
                         cur_req, ctrl_q, e_ctrl, data_lo_q, m_lo, data_hi_q, 32'(m_hi),
                         learn_cnt_q, m_cnt, wipe_q, m_wipe);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic wait_idle();
        while (ctrl_q[31]) @(negedge clk);
    endtask

    task automatic cmd(logic [31:0] d);
        wr(SEL_CTRL, d);
        wait_idle();
    endtask

    task automatic summary();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    localparam logic [31:0] C_LOOK = 32'h1 << 16;
    localparam logic [31:0] C_WR   = 32'h1 << 17;
    localparam logic [31:0] C_CLR  = 32'h1 << 18;
    localparam logic [31:0] C_RD   = 32'h1 << 19;
    localparam logic [31:0] C_WAIT = 32'h1 << 20;
    localparam logic [31:0] C_DEL  = 32'h1 << 21;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_q, 0);
        chk("R1 hi", data_hi_q, 0);
        chk("R1 cnt", 32'(learn_cnt_q), 0);

        // R5 miss on empty slot 6
        cur_req = "R5";
        wr(SEL_LO, 32'h44332211);
        wr(SEL_HI, 32'h00000655);
        wr(SEL_CTRL, C_LOOK);
        chk("R2 busy after lookup", 32'(ctrl_q[31]), 1);
        @(negedge clk);
        chk("R2 busy one cycle", 32'(ctrl_q[31]), 0);
        chk("R5 miss image", data_hi_q, 32'h001F0655);
        chk("R5 index", ctrl_q, 32'h6);

        // R6 write, R4 hit
        cur_req = "R6";
        wr(SEL_HI, 32'h01050655);
        cmd(C_WR | 32'h6);
        cur_req = "R4";
        wr(SEL_HI, 32'h00000655);
        cmd(C_LOOK);
        chk("R4 hit image", data_hi_q, 32'h01050655);
        chk("R4 hit index", ctrl_q, 32'h6);

        // R6 read with and without wait
        cur_req = "R6";
        wr(SEL_LO, 32'h0);
        cmd(C_RD | 32'h6);
        chk("R6 read keeps lo", data_lo_q, 32'h0);
        chk("R6 read hi", data_hi_q, 32'h01050655);
        cmd(C_RD | C_WAIT | 32'h6);
        chk("R6 read wait lo", data_lo_q, 32'h44332211);

        // R12 collision in slot 6
        cur_req = "R12";
        wr(SEL_LO, 32'hAABBCCDD);
        wr(SEL_HI, 32'h00001677);
        cmd(C_LOOK);
        chk("R12 collision miss", data_hi_q, 32'h001F1677);
        chk("R12 same slot", ctrl_q, 32'h6);

        // more entries: static at 3, dynamic at 9
        cur_req = "R6";
        wr(SEL_LO, 32'h01010101);
        wr(SEL_HI, 32'h01810301);
        cmd(C_WR | 32'h3);
        wr(SEL_HI, 32'h01030902);
        cmd(C_WR | 32'h9);

        // R7 clear slot 6
        cur_req = "R7";
        cmd(C_CLR | 32'h6);
        cmd(C_RD | 32'h6);
        chk("R7 cleared", data_hi_q, 32'h0);

        // R8 flush port 0, with R3 writes during the scan
        cur_req = "R8";
        wr(SEL_LO, 32'h12345678);
        wr(SEL_CTRL, C_DEL | 32'h01);
        cur_req = "R3";
        wr(SEL_LO, 32'hDEADBEEF);
        wr(SEL_CTRL, C_LOOK | 32'h55);
        wr(SEL_LCNT, 32'h1);
        chk("R3 lo ignored", data_lo_q, 32'h12345678);
        chk("R3 ctrl ignored", ctrl_q, 32'h80000001);
        chk("R3 count taken", 32'(learn_cnt_q), 1);
        wait_idle();
        cur_req = "R8";
        cmd(C_RD | 32'h3);
        chk("R8 static kept", data_hi_q, 32'h01800301);
        cmd(C_RD | 32'h9);
        chk("R8 port removed", data_hi_q, 32'h01020902);
        cmd(C_DEL | 32'h02);
        cmd(C_RD | 32'h9);
        chk("R8 empty dropped", data_hi_q, 32'h0);

        // R9 wipe timing
        cur_req = "R9";
        wr(SEL_TABLE, 32'h1);
        chk("R9 wipe set", 32'(wipe_q), 1);
        repeat (DEPTH - 1) @(negedge clk);
        chk("R9 still wiping", 32'(wipe_q), 1);
        @(negedge clk);
        chk("R9 wipe done", 32'(wipe_q), 0);
        chk("R2 scan busy ends", 32'(ctrl_q[31]), 0);
        cmd(C_RD | 32'h3);
        chk("R9 entry gone", data_hi_q, 32'h0);

        // R10 counter modes
        cur_req = "R10";
        wr(SEL_LCNT, 32'h1);
        wr(SEL_LCNT, 32'h1);
        chk("R10 inc", 32'(learn_cnt_q), 3);
        wr(SEL_LCNT, 32'h2);
        chk("R10 dec", 32'(learn_cnt_q), 2);
        wr(SEL_LCNT, 32'h0);
        chk("R10 hold", 32'(learn_cnt_q), 2);
        wr(SEL_LCNT, 32'h3);
        wr(SEL_LCNT, 32'h2);
        chk("R10 floor", 32'(learn_cnt_q), 0);
        for (int i = 0; i < DEPTH + 2; i++) wr(SEL_LCNT, 32'h1);
        chk("R10 ceiling", 32'(learn_cnt_q), DEPTH);

        // R11 priority among command bits
        cur_req = "R11";
        wr(SEL_LO, 32'h0A0B0C0D);
        wr(SEL_HI, 32'h01400705);
        cmd(C_WR | C_CLR | C_DEL | 32'h5);
        cmd(C_RD | 32'h5);
        chk("R11 write beats clear", data_hi_q, 32'h01400705);
        cmd(C_CLR | C_RD | 32'h5);
        cmd(C_RD | 32'h5);
        chk("R11 clear beats read", data_hi_q, 32'h0);

        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

endmodule